// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small multi-cycle processor built around one 16-bit accumulator. Every instruction is a 16-bit word whose upper four bits select the operation and whose lower twelve bits name a word address in a 4096-word, word-addressed memory. The core steps each instruction through a fixed series of register transfers between a 12-bit address register, a 16-bit memory data register, the accumulator, a 12-bit program counter and a 16-bit instruction register. Each instruction therefore takes a known number of clock cycles, and there is no overlap between instructions.

The core drives a synchronous memory port. It presents an address from its address register, and the read word is expected on `mem_rdata` one clock later. A write happens in a single cycle with `mem_we` high. An 8-bit input register captures `in_data` whenever `in_strobe` is high. An 8-bit output register is loaded by the output instruction, and `out_valid` pulses for one cycle when that happens. A halt instruction parks the core and raises `halt`, so that a test environment can inspect memory and outputs afterwards.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, all internal registers clear, and `halt`, `out_valid`, `mem_we`, `out_data` and `mem_addr` all read zero.
- R2: An instruction word is opcode = bits 15:12 and address X = bits 11:0. Opcode 1 (load) sets AC to M[X].
- R3: Opcode 14 (add) sets AC to AC + M[X], and opcode 3 (subtract) sets AC to AC - M[X]. Both wrap modulo 2^16.
- R4: Opcode 2 (store) writes AC to M[X] in exactly one cycle of `mem_we`.
- R5: Opcode 8 (conditional skip) tests bits 11:10. Code 00 skips when AC is negative, 01 when AC is zero, 10 when AC is above zero, and 11 never skips. A skip adds one more to PC, so the next instruction is bypassed.
- R6: Opcode 9 sets PC to X. Opcode 12 sets PC to the low 12 bits of M[X].
- R7: Opcode 13 sets AC to M[M[X]]. Opcode 11 sets AC to AC + M[M[X]]. In both, the pointer is the low 12 bits of M[X].
- R8: Opcode 4 sets AC to the 8-bit input register, zero-extended. The input register loads only in cycles where `in_strobe` is high.
- R9: Opcode 5 copies AC[7:0] to `out_data` and raises `out_valid` for exactly one cycle.
- R10: Opcode 10 clears AC. Opcodes 0, 7 and 15 change no architectural state.
- R11: PC increments modulo 4096, so execution continues at address 0 after address 4095.
- R12: Opcode 6 raises `halt` permanently until reset. While halted there are no memory writes and `mem_addr` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_rdata | input | 16 | Read word, valid one cycle after the address is presented |
| mem_wdata | output | 16 | Write word |
| mem_we | output | 1 | Write enable, one cycle per store |
| in_data | input | 8 | Input device data |
| in_strobe | input | 1 | Loads the input register from `in_data` |
| out_data | output | 8 | Output register |
| out_valid | output | 1 | One-cycle pulse when the output register is loaded |
| halt | output | 1 | Core is halted |

## Verification
The bench aims at the conditional skip at every sign boundary: zero under the greater-than code, the most negative value under the negative code, and the unused code 11. A wrong comparison shows up as a store that was bypassed, or one that was not, which leaves the sentinel word in memory or overwrites it. The indirect forms are run with pointer words that differ from the operand. A core that used the first read instead of the second would load the pointer itself. A program is also made to run off the top of memory at address 4095. A core whose PC did not wrap would fetch from the wrong address and never halt. The bench then confirms three more things: the output pulse lasts one cycle, a store writes only once, and a halted core keeps its address and writes nothing.

// File: rtl/acc_pkg.sv
// Package: shared encodings for the accumulator core.
// Assumes a 4-bit opcode field above the address field of each word.
package acc_pkg;

    typedef enum logic [3:0] {
        OP_NOP0   = 4'h0,
        OP_LOAD   = 4'h1,
        OP_STORE  = 4'h2,
        OP_SUB    = 4'h3,
        OP_INPUT  = 4'h4,
        OP_OUTPUT = 4'h5,
        OP_HALT   = 4'h6,
        OP_NOP7   = 4'h7,
        OP_SKIP   = 4'h8,
        OP_JUMP   = 4'h9,
        OP_CLEAR  = 4'hA,
        OP_ADDI   = 4'hB,
        OP_JUMPI  = 4'hC,
        OP_LOADI  = 4'hD,
        OP_ADD    = 4'hE,
        OP_NOPF   = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_A,
        ST_FETCH_W,
        ST_FETCH_I,
        ST_DECODE,
        ST_RD_W,
        ST_RD_D,
        ST_IND,
        ST_RD2_W,
        ST_RD2_D,
        ST_EXEC,
        ST_WRITE,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_HOLD,
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_ZEXT,
        ALU_ZERO
    } alu_op_e;

    localparam int unsigned OPC_W = 4;

endpackage

// File: rtl/acc_alu.sv
// Module: accumulator arithmetic unit.
// Computes the next accumulator value from the current accumulator, the
// memory data register and the input register. Purely combinational;
// the caller decides in which cycle the result is captured.
module acc_alu
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IO_W   = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   mbr,
    input  logic [IO_W-1:0]     io_in,
    output logic [DATA_W-1:0]   y
);

    localparam int unsigned PAD_W = DATA_W - IO_W;

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_PASS: y = mbr;
            ALU_ADD:  y = acc + mbr;
            ALU_SUB:  y = acc - mbr;
            ALU_ZEXT: y = {{PAD_W{1'b0}}, io_in};
            ALU_ZERO: y = '0;
            default:  y = acc;
        endcase
    end

endmodule

// File: rtl/acc_skip_unit.sv
// Module: skip condition evaluator.
// Tests the accumulator sign against a 2-bit condition code:
// 00 negative, 01 zero, 10 positive, 11 never. Combinational.
module acc_skip_unit #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [1:0]        cond,
    input  logic [DATA_W-1:0] acc,
    output logic              take
);

    logic is_neg;
    logic is_zero;
    logic is_pos;

    // Classify the accumulator value.
    always_comb begin
        is_neg  = acc[DATA_W-1];
        is_zero = (acc == '0);
        is_pos  = !is_neg && !is_zero;
    end

    // Pick the flag named by the condition code.
    always_comb begin
        case (cond)
            2'b00:   take = is_neg;
            2'b01:   take = is_zero;
            2'b10:   take = is_pos;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_seq.sv
// Module: instruction sequencer.
// Walks the fetch, operand-read, indirect, execute and write microsteps
// for the opcode held in the instruction register. Assumes a memory with
// one cycle of read latency, hence the wait states.
module acc_seq
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e opc,
    output state_e  state
);

    state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_FETCH_A: nxt = ST_FETCH_W;
            ST_FETCH_W: nxt = ST_FETCH_I;
            ST_FETCH_I: nxt = ST_DECODE;
            ST_DECODE: begin
                case (opc)
                    OP_LOAD, OP_SUB, OP_ADD,
                    OP_ADDI, OP_LOADI, OP_JUMPI: nxt = ST_RD_W;
                    OP_STORE:                    nxt = ST_WRITE;
                    default:                     nxt = ST_EXEC;
                endcase
            end
            ST_RD_W:  nxt = ST_RD_D;
            ST_RD_D:  nxt = (opc == OP_ADDI || opc == OP_LOADI) ? ST_IND : ST_EXEC;
            ST_IND:   nxt = ST_RD2_W;
            ST_RD2_W: nxt = ST_RD2_D;
            ST_RD2_D: nxt = ST_EXEC;
            ST_EXEC:  nxt = (opc == OP_HALT) ? ST_HALT : ST_FETCH_A;
            ST_WRITE: nxt = ST_FETCH_A;
            ST_HALT:  nxt = ST_HALT;
            default:  nxt = ST_FETCH_A;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_A;
        else        state <= nxt;
    end

endmodule

// File: rtl/acc_core.sv
// Module: accumulator processor core (top).
// Holds the architectural registers and performs the register transfer
// selected by the sequencer state each cycle. Assumes a synchronous
// memory that returns the word at mem_addr one cycle later.
module acc_core
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_strobe,
    output logic [IO_W-1:0]   out_data,
    output logic              out_valid,
    output logic              halt
);

    localparam int unsigned FLD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] ir;
    logic [ADDR_W-1:0] mar;
    logic [ADDR_W-1:0] pc;
    logic [IO_W-1:0]   in_reg;
    logic [IO_W-1:0]   out_reg;
    logic              out_pulse;

    opcode_e           opc;
    state_e            state;
    alu_op_e           alu_op;
    logic [DATA_W-1:0] alu_y;
    logic              skip_take;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] mbr_addr;

    // Split the instruction register into its fields.
    always_comb begin
        opc      = opcode_e'(ir[DATA_W-1 -: FLD_W]);
        ir_addr  = ir[ADDR_W-1:0];
        mbr_addr = mbr[ADDR_W-1:0];
    end

    // Map the opcode to an accumulator operation.
    always_comb begin
        case (opc)
            OP_LOAD, OP_LOADI: alu_op = ALU_PASS;
            OP_ADD, OP_ADDI:   alu_op = ALU_ADD;
            OP_SUB:            alu_op = ALU_SUB;
            OP_INPUT:          alu_op = ALU_ZEXT;
            OP_CLEAR:          alu_op = ALU_ZERO;
            default:           alu_op = ALU_HOLD;
        endcase
    end

    acc_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .opc   (opc),
        .state (state)
    );

    acc_alu #(
        .DATA_W (DATA_W),
        .IO_W   (IO_W)
    ) u_alu (
        .op    (alu_op),
        .acc   (acc),
        .mbr   (mbr),
        .io_in (in_reg),
        .y     (alu_y)
    );

    acc_skip_unit #(
        .DATA_W (DATA_W)
    ) u_skip (
        .cond (ir[ADDR_W-1 -: 2]),
        .acc  (acc),
        .take (skip_take)
    );

    // Input register: captures device data on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_reg <= '0;
        else if (in_strobe) in_reg <= in_data;
    end

    // Datapath register transfers, one set per sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            mbr       <= '0;
            ir        <= '0;
            mar       <= '0;
            pc        <= '0;
            out_reg   <= '0;
            out_pulse <= 1'b0;
        end else begin
            out_pulse <= 1'b0;
            case (state)
                ST_FETCH_A: mar <= pc;
                ST_FETCH_I: begin
                    ir <= mem_rdata;
                    pc <= pc + 1'b1;
                end
                ST_DECODE: begin
                    mar <= ir_addr;
                    if (opc == OP_STORE) mbr <= acc;
                end
                ST_RD_D, ST_RD2_D: mbr <= mem_rdata;
                ST_IND:            mar <= mbr_addr;
                ST_EXEC: begin
                    acc <= alu_y;
                    case (opc)
                        OP_SKIP:  if (skip_take) pc <= pc + 1'b1;
                        OP_JUMP:  pc <= ir_addr;
                        OP_JUMPI: pc <= mbr_addr;
                        OP_OUTPUT: begin
                            out_reg   <= acc[IO_W-1:0];
                            out_pulse <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Drive the block outputs from registered state.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_we    = (state == ST_WRITE);
        out_data  = out_reg;
        out_valid = out_pulse;
        halt      = (state == ST_HALT);
    end

endmodule

// File: rtl/acc_core_chk.sv
// Module: protocol checker for the accumulator core, attached by bind.
// Watches only the top-level ports; assumes synchronous active-low reset.
module acc_core_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid
);

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R12
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we);

    // R12
    halt_addr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(mem_addr));

    // R9
    out_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .out_valid (out_valid)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
// Bench: runs a fixed four-word program once per table vector, then
// directed tests for reset, output pulse, store count, halt and PC wrap.
module acc_core_tb;

    typedef struct packed {
        logic [15:0] ins;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{16'h1101, 16'h1111, 16'h2222, 16'h2222, 4'd2},   // R2 load
        '{16'hE101, 16'h1234, 16'h0101, 16'h1335, 4'd3},   // R3 add
        '{16'hE101, 16'hFFFF, 16'h0001, 16'h0000, 4'd3},   // R3 add wrap
        '{16'h3101, 16'h0005, 16'h0007, 16'hFFFE, 4'd3},   // R3 sub borrow
        '{16'h3101, 16'h8000, 16'h0001, 16'h7FFF, 4'd3},   // R3 sub wrap
        '{16'h8000, 16'h8000, 16'h0000, 16'hDEAD, 4'd5},   // R5 neg taken
        '{16'h8000, 16'h0005, 16'h0000, 16'h0005, 4'd5},   // R5 neg not
        '{16'h8400, 16'h0000, 16'h0000, 16'hDEAD, 4'd5},   // R5 zero taken
        '{16'h8400, 16'h0001, 16'h0000, 16'h0001, 4'd5},   // R5 zero not
        '{16'h8800, 16'h0001, 16'h0000, 16'hDEAD, 4'd5},   // R5 pos taken
        '{16'h8800, 16'hFFFF, 16'h0000, 16'hFFFF, 4'd5},   // R5 pos on neg
        '{16'h8800, 16'h0000, 16'h0000, 16'h0000, 4'd5},   // R5 pos on zero
        '{16'h8C00, 16'h0001, 16'h0000, 16'h0001, 4'd5},   // R5 code 11
        '{16'h9003, 16'h0001, 16'h0000, 16'hDEAD, 4'd6},   // R6 jump
        '{16'hC101, 16'h0001, 16'h0003, 16'hDEAD, 4'd6},   // R6 jump via M
        '{16'hD101, 16'h4321, 16'h0100, 16'h4321, 4'd7},   // R7 load via M
        '{16'hB101, 16'h0102, 16'h0100, 16'h0204, 4'd7},   // R7 add via M
        '{16'hA000, 16'h7777, 16'h0000, 16'h0000, 4'd10},  // R10 clear
        '{16'h7000, 16'h7777, 16'h0000, 16'h7777, 4'd10},  // R10 nop 7
        '{16'h0000, 16'h1357, 16'h0000, 16'h1357, 4'd10},  // R10 nop 0
        '{16'hF000, 16'h2468, 16'h0000, 16'h2468, 4'd10},  // R10 nop F
        '{16'h4000, 16'h9999, 16'h0000, 16'h005A, 4'd8},   // R8 input, later data ignored
        '{16'h5000, 16'h1234, 16'h0000, 16'h1234, 4'd9}    // R9 output keeps AC
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [7:0]  in_data = 8'h00;
    logic        in_strobe = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        halt;

    logic [15:0] mem [4096];
    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [15:0] tb_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt;
    int ov_cnt;

    always #2.5 clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .in_data   (in_data),
        .in_strobe (in_strobe),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halt      (halt)
    );

    // Memory model: bench loader port has priority over the core.
    always @(posedge clk) begin
        if (tb_we)       mem[tb_addr]  <= tb_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Count write cycles and output pulses since the last reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= 0;
            ov_cnt <= 0;
        end else begin
            if (mem_we)    wr_cnt <= wr_cnt + 1;
            if (out_valid) ov_cnt <= ov_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        tb_addr = a;
        tb_data = d;
        tb_we   = 1'b1;
        @(negedge clk);
        tb_we   = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_template(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b);
        poke(12'h000, 16'h1100);
        poke(12'h001, ins);
        poke(12'h002, 16'h2102);
        poke(12'h003, 16'h6000);
        poke(12'h100, a);
        poke(12'h101, b);
        poke(12'h102, 16'hDEAD);
    endtask

    // Release reset, strobe 0x5A into the input register, then change the
    // input data without a strobe, and wait for halt.
    task automatic run_to_halt(input string req);
        rst_n     = 1'b1;
        in_data   = 8'h5A;
        in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
        in_data   = 8'hFF;
        for (int i = 0; i < 800 && !halt; i++) @(negedge clk);
        check({req, " halt reached"}, {15'd0, halt}, 16'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] addr_hold;
        int          wr_hold;

        // R1 reset state
        hold_reset();
        check("R1 halt",      {15'd0, halt},      16'd0);
        check("R1 out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 mem_we",    {15'd0, mem_we},    16'd0);
        check("R1 out_data",  {8'd0, out_data},   16'd0);
        check("R1 mem_addr",  {4'd0, mem_addr},   16'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            hold_reset();
            load_template(VECS[i].ins, VECS[i].a, VECS[i].b);
            run_to_halt($sformatf("R%0d vec %0d", VECS[i].req, i));
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), mem[12'h102], VECS[i].exp);
        end

        // R9 output register and single pulse
        hold_reset();
        load_template(16'h5000, 16'hAB34, 16'h0000);
        run_to_halt("R9");
        check("R9 out_data", {8'd0, out_data}, 16'h0034);
        check("R9 pulse count", 16'(ov_cnt), 16'd1);

        // R4 one write cycle per store
        hold_reset();
        load_template(16'h1101, 16'h0000, 16'hCAFE);
        run_to_halt("R4");
        check("R4 stored word", mem[12'h102], 16'hCAFE);
        check("R4 write cycles", 16'(wr_cnt), 16'd1);

        // R12 halt freezes the core
        addr_hold = mem_addr;
        wr_hold   = wr_cnt;
        repeat (20) @(negedge clk);
        check("R12 halt held",  {15'd0, halt}, 16'd1);
        check("R12 addr still", {4'd0, mem_addr}, {4'd0, addr_hold});
        check("R12 no writes",  16'(wr_cnt), 16'(wr_hold));

        // R11 execution runs from 0xFFF onto address 0
        hold_reset();
        poke(12'h000, 16'h8400);
        poke(12'h001, 16'h9003);
        poke(12'h002, 16'h9FFF);
        poke(12'h003, 16'h2102);
        poke(12'h004, 16'h6000);
        poke(12'hFFF, 16'h1100);
        poke(12'h100, 16'h0042);
        poke(12'h102, 16'hDEAD);
        run_to_halt("R11");
        check("R11 wrap result", mem[12'h102], 16'h0042);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule